// File: doc/BRIEF.md
# Page Protection and Fault Sequencer

This block takes one memory access request per handshake and decides whether the access may proceed. It applies a fixed priority. If translation is switched off for this kind of access, the address is passed through with full permission. Otherwise a block-translation result is used when it grants access. If it does not, the page-table result is used, and its protection code is decoded against a key taken from the segment attributes and the current privilege mode. The block-translation unit, the page-table walker and the segment lookup all work outside this block. Their results arrive on input ports in the same cycle as the request and must stay valid while `req_valid` is high.

When an access is refused, the block reports it in one of two ways, chosen by `cfg_sw_reload`:
- **Status mode:** data faults load a fault-address register and a status word, and a storage-exception code is issued.
- **Software-reload mode:** the missing address is stored in an instruction-miss or data-miss register, a temporary-register-mode pulse is raised, and a reload vector is issued.

A request flagged `req_no_exc` returns only the refusal and has no side effects.

Requests use a valid/ready handshake. `req_ready` is high whenever the response register is empty or is being consumed in the same cycle. A response appears one cycle after acceptance and holds steady while `rsp_ready` is low. Back-pressure on the response port therefore stalls the request port.

Top module: `xlat_fault_seq`

## Requirements
- R1: An instruction fetch with `cfg_instr_xlat_en` low, or a data access with `cfg_data_xlat_en` low, is granted with permission 2 (read/write), and `rsp_paddr` equals `req_vaddr`.
- R2: If `blk_hit` is set and the block permission is nonzero after write limiting, the block result wins. `rsp_paddr` is `blk_paddr` and the page result is ignored. Block permission 3 counts as read/write. A write to a block permission of 1 (read-only) counts as a miss.
- R3: The protection key is 1 when `cfg_problem` is 1 and `seg_ukey` is 1, or when `cfg_problem` is 0 and `seg_skey` is 1. In every other case the key is 0.
- R4: Permission encoding is 0 = none, 1 = read-only, 2 = read/write.
  - With key 1, `pg_pp` 0 gives 0, codes 1 and 3 give 1, and code 2 gives 2.
  - With key 0, code 3 gives 1 and every other code gives 2.
  - A write to a permission of 1 becomes 0. A granted write always reports 2.
  - A page grant has `rsp_paddr` = {`pg_frame`, `req_vaddr[PAGE_BITS-1:0]`}.
- R5: An instruction fetch is refused when `seg_noexec` or `pg_guarded` is set, even if the page entry matches. Data accesses ignore both bits.
- R6: A status-mode data fault does three things:
  - It loads `dfault_addr` with the virtual address.
  - It loads `dfault_status` with bit 27 if `pg_match` was set, or bit 30 if not, plus bit 25 for a write.
  - It issues code 0x03.
  A status-mode instruction fault issues code 0x04 and leaves both registers unchanged.
- R7: A software-reload fault does three things:
  - It loads `imiss_addr` (instruction) or `dmiss_addr` (data) with the virtual address.
  - It pulses `fault_tgpr`.
  - It issues code 0x10 for an instruction fetch, 0x11 for a data load, or 0x12 for a data store.
  `dfault_addr` and `dfault_status` are unchanged.
- R8: A refused request with `req_no_exc` set returns `rsp_grant` 0 and `rsp_perm` 0. It raises no fault pulse and changes no fault register.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and all response fields hold their values.
- R10: `fault_pulse` is high for exactly one cycle, the first cycle of the refused response. `fault_code` is valid from that cycle on.
- R11: All fault registers reset to 0 and keep their value until the next fault of their own kind overwrites them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sw_reload | input | 1 | 1 selects software-reload fault reporting |
| cfg_instr_xlat_en | input | 1 | Instruction translation enable |
| cfg_data_xlat_en | input | 1 | Data translation enable |
| cfg_problem | input | 1 | 1 = problem (user) state |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_vaddr | input | AW | Effective address |
| req_instr | input | 1 | 1 = instruction fetch |
| req_write | input | 1 | 1 = store |
| req_no_exc | input | 1 | Suppress fault side effects |
| blk_hit | input | 1 | Block translation matched |
| blk_perm | input | 2 | Block permission (0 none, 1 read-only, 2/3 read/write) |
| blk_paddr | input | AW | Block-translated address |
| pg_match | input | 1 | Page-table entry found |
| pg_pp | input | 2 | Page protection code |
| pg_guarded | input | 1 | Page guarded |
| pg_frame | input | AW-PAGE_BITS | Physical page frame |
| seg_ukey | input | 1 | Segment user-state key bit |
| seg_skey | input | 1 | Segment privileged-state key bit |
| seg_noexec | input | 1 | Segment no-execute bit |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_grant | output | 1 | Access allowed |
| rsp_perm | output | 2 | Granted permission |
| rsp_paddr | output | AW | Physical address (0 when refused) |
| fault_pulse | output | 1 | One-cycle fault indication |
| fault_code | output | 8 | Exception or reload vector code |
| fault_tgpr | output | 1 | One-cycle temporary-register-mode set |
| dfault_addr | output | AW | Data fault address register |
| dfault_status | output | 32 | Data fault status word |
| imiss_addr | output | AW | Instruction miss address register |
| dmiss_addr | output | AW | Data miss address register |

## Verification
Every cycle, the assertions check the following:
- The fault pulse lasts a single cycle and lines up with a refused response.
- A response under back-pressure stays frozen.
- A translation-off data access returns its own address.
- A granted write never reports read-only.
- Suppressed requests raise no pulse.
- The data-fault address register changes only on a pulse cycle.

Only the bench scenarios can show the following:
- The full key and protection-code table, including which privilege mode selects which key bit.
- The priority of the block result over the page result.
- The refusals caused by no-execute and guarded pages.
- The exact status-word bits and vector codes of each reporting mode.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int unsigned STAT_W          = 32;
  localparam int unsigned ST_NOTFOUND_BIT = 30;
  localparam int unsigned ST_PROT_BIT     = 27;
  localparam int unsigned ST_STORE_BIT    = 25;

  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_RO   = 2'd1,
    PERM_RW   = 2'd2
  } perm_e;

  localparam logic [7:0] EXC_DATA_STORAGE  = 8'h03;
  localparam logic [7:0] EXC_INSTR_STORAGE = 8'h04;
  localparam logic [7:0] VEC_IMISS         = 8'h10;
  localparam logic [7:0] VEC_DLOAD_MISS    = 8'h11;
  localparam logic [7:0] VEC_DSTORE_MISS   = 8'h12;

  // A store never proceeds on a read-only grant.
  function automatic perm_e limit_write(perm_e p, logic is_write);
    return (is_write && p == PERM_RO) ? PERM_NONE : p;
  endfunction

endpackage

// File: rtl/xlat_prot_decode.sv
module xlat_prot_decode
  import xlat_pkg::*;
(
  input  logic       problem,
  input  logic       seg_ukey,
  input  logic       seg_skey,
  input  logic       seg_noexec,
  input  logic       pg_guarded,
  input  logic [1:0] pp,
  input  logic       is_write,
  input  logic       is_instr,
  output perm_e      perm
);

  logic  key;
  perm_e raw;

  always_comb begin
    key = (problem && seg_ukey) || (!problem && seg_skey);
    if (key) begin
      unique case (pp)
        2'd0:    raw = PERM_NONE;
        2'd2:    raw = PERM_RW;
        default: raw = PERM_RO;
      endcase
    end else begin
      raw = (pp == 2'd3) ? PERM_RO : PERM_RW;
    end
    if (is_instr && (seg_noexec || pg_guarded)) begin
      perm = PERM_NONE;
    end else begin
      perm = limit_write(raw, is_write);
    end
  end

endmodule

// File: rtl/xlat_path_select.sv
module xlat_path_select
  import xlat_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned PAGE_BITS = 12
) (
  input  logic                  bypass,
  input  logic [AW-1:0]         vaddr,
  input  logic                  is_write,
  input  logic                  blk_hit,
  input  logic [1:0]            blk_perm,
  input  logic [AW-1:0]         blk_paddr,
  input  logic                  pg_match,
  input  perm_e                 pg_perm,
  input  logic [AW-PAGE_BITS-1:0] pg_frame,
  output logic                  grant,
  output logic [1:0]            perm,
  output logic [AW-1:0]         paddr
);

  perm_e blk_eff;

  always_comb begin
    unique case (blk_perm)
      2'd0:    blk_eff = PERM_NONE;
      2'd1:    blk_eff = PERM_RO;
      default: blk_eff = PERM_RW;
    endcase
    blk_eff = limit_write(blk_eff, is_write);

    grant = 1'b0;
    perm  = PERM_NONE;
    paddr = '0;
    if (bypass) begin
      grant = 1'b1;
      perm  = PERM_RW;
      paddr = vaddr;
    end else if (blk_hit && blk_eff != PERM_NONE) begin
      grant = 1'b1;
      perm  = blk_eff;
      paddr = blk_paddr;
    end else if (pg_match && pg_perm != PERM_NONE) begin
      grant = 1'b1;
      perm  = pg_perm;
      paddr = {pg_frame, vaddr[PAGE_BITS-1:0]};
    end
  end

endmodule

// File: rtl/xlat_fault_regs.sv
module xlat_fault_regs
  import xlat_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              sw_mode,
  input  logic              is_instr,
  input  logic              is_write,
  input  logic              matched,
  input  logic [AW-1:0]     vaddr,
  output logic [7:0]        code,
  output logic [AW-1:0]     dfault_addr,
  output logic [STAT_W-1:0] dfault_status,
  output logic [AW-1:0]     imiss_addr,
  output logic [AW-1:0]     dmiss_addr
);

  logic [STAT_W-1:0] status_next;
  logic [7:0]        code_next;

  always_comb begin
    status_next = '0;
    if (matched) status_next[ST_PROT_BIT]     = 1'b1;
    else         status_next[ST_NOTFOUND_BIT] = 1'b1;
    if (is_write) status_next[ST_STORE_BIT]   = 1'b1;

    if (sw_mode) begin
      if (is_instr)      code_next = VEC_IMISS;
      else if (is_write) code_next = VEC_DSTORE_MISS;
      else               code_next = VEC_DLOAD_MISS;
    end else begin
      code_next = is_instr ? EXC_INSTR_STORAGE : EXC_DATA_STORAGE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code          <= '0;
      dfault_addr   <= '0;
      dfault_status <= '0;
      imiss_addr    <= '0;
      dmiss_addr    <= '0;
    end else if (fire) begin
      code <= code_next;
      if (sw_mode) begin
        if (is_instr) imiss_addr <= vaddr;
        else          dmiss_addr <= vaddr;
      end else if (!is_instr) begin
        dfault_addr   <= vaddr;
        dfault_status <= status_next;
      end
    end
  end

endmodule

// File: rtl/xlat_fault_seq.sv
module xlat_fault_seq
  import xlat_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned PAGE_BITS = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_sw_reload,
  input  logic                    cfg_instr_xlat_en,
  input  logic                    cfg_data_xlat_en,
  input  logic                    cfg_problem,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [AW-1:0]           req_vaddr,
  input  logic                    req_instr,
  input  logic                    req_write,
  input  logic                    req_no_exc,
  input  logic                    blk_hit,
  input  logic [1:0]              blk_perm,
  input  logic [AW-1:0]           blk_paddr,
  input  logic                    pg_match,
  input  logic [1:0]              pg_pp,
  input  logic                    pg_guarded,
  input  logic [AW-PAGE_BITS-1:0] pg_frame,
  input  logic                    seg_ukey,
  input  logic                    seg_skey,
  input  logic                    seg_noexec,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic                    rsp_grant,
  output logic [1:0]              rsp_perm,
  output logic [AW-1:0]           rsp_paddr,
  output logic                    fault_pulse,
  output logic [7:0]              fault_code,
  output logic                    fault_tgpr,
  output logic [AW-1:0]           dfault_addr,
  output logic [31:0]             dfault_status,
  output logic [AW-1:0]           imiss_addr,
  output logic [AW-1:0]           dmiss_addr
);

  logic          accept;
  logic          bypass;
  logic          fire;
  perm_e         pg_perm;
  logic          sel_grant;
  logic [1:0]    sel_perm;
  logic [AW-1:0] sel_paddr;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign bypass    = req_instr ? !cfg_instr_xlat_en : !cfg_data_xlat_en;
  assign fire      = accept && !sel_grant && !req_no_exc;

  xlat_prot_decode u_decode (
    .problem    (cfg_problem),
    .seg_ukey   (seg_ukey),
    .seg_skey   (seg_skey),
    .seg_noexec (seg_noexec),
    .pg_guarded (pg_guarded),
    .pp         (pg_pp),
    .is_write   (req_write),
    .is_instr   (req_instr),
    .perm       (pg_perm)
  );

  xlat_path_select #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_select (
    .bypass    (bypass),
    .vaddr     (req_vaddr),
    .is_write  (req_write),
    .blk_hit   (blk_hit),
    .blk_perm  (blk_perm),
    .blk_paddr (blk_paddr),
    .pg_match  (pg_match),
    .pg_perm   (pg_perm),
    .pg_frame  (pg_frame),
    .grant     (sel_grant),
    .perm      (sel_perm),
    .paddr     (sel_paddr)
  );

  xlat_fault_regs #(.AW(AW)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .fire          (fire),
    .sw_mode       (cfg_sw_reload),
    .is_instr      (req_instr),
    .is_write      (req_write),
    .matched       (pg_match),
    .vaddr         (req_vaddr),
    .code          (fault_code),
    .dfault_addr   (dfault_addr),
    .dfault_status (dfault_status),
    .imiss_addr    (imiss_addr),
    .dmiss_addr    (dmiss_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_grant   <= 1'b0;
      rsp_perm    <= '0;
      rsp_paddr   <= '0;
      fault_pulse <= 1'b0;
      fault_tgpr  <= 1'b0;
    end else begin
      fault_pulse <= fire;
      fault_tgpr  <= fire && cfg_sw_reload;
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_grant <= sel_grant;
        rsp_perm  <= sel_perm;
        rsp_paddr <= sel_paddr;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/xlat_fault_seq_chk.sv
module xlat_fault_seq_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_data_xlat_en,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_vaddr,
  input logic          req_instr,
  input logic          req_write,
  input logic          req_no_exc,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          rsp_grant,
  input logic [1:0]    rsp_perm,
  input logic [AW-1:0] rsp_paddr,
  input logic          fault_pulse,
  input logic [AW-1:0] dfault_addr
);

  AST_BYPASS_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_instr && !cfg_data_xlat_en |=> rsp_grant && rsp_paddr == $past(req_vaddr)); // R1

  AST_WRITE_FULL_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write |=> !rsp_grant || rsp_perm == 2'd2); // R4

  AST_NOEXC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_no_exc |=> !fault_pulse); // R8

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_grant) && $stable(rsp_perm) && $stable(rsp_paddr)); // R9

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> !fault_pulse); // R10

  AST_PULSE_WITH_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> rsp_valid && !rsp_grant); // R10

  AST_DAR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_pulse |-> $stable(dfault_addr)); // R11

endmodule

bind xlat_fault_seq xlat_fault_seq_chk #(.AW(AW)) chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .cfg_data_xlat_en (cfg_data_xlat_en),
  .req_valid        (req_valid),
  .req_ready        (req_ready),
  .req_vaddr        (req_vaddr),
  .req_instr        (req_instr),
  .req_write        (req_write),
  .req_no_exc       (req_no_exc),
  .rsp_valid        (rsp_valid),
  .rsp_ready        (rsp_ready),
  .rsp_grant        (rsp_grant),
  .rsp_perm         (rsp_perm),
  .rsp_paddr        (rsp_paddr),
  .fault_pulse      (fault_pulse),
  .dfault_addr      (dfault_addr)
);

// File: tb/xlat_fault_seq_tb_top.sv
module xlat_fault_seq_tb_top;

  localparam int AW = 32;
  localparam int PB = 12;
  localparam int NV = 24;

  // Vector layout: [27]instr [26]write [25]noexc [24]xlat_en [23]problem [22]sw
  // [21]blk_hit [20:19]blk_perm [18]pg_match [17:16]pp [15]guard [14]ukey [13]skey
  // [12]noexec [11]exp_grant [10:9]exp_perm [8]exp_fault [7:0]exp_code
  function automatic logic [27:0] mk(
    logic i, logic w, logic ne, logic xe, logic pr, logic sw,
    logic bh, logic [1:0] bp, logic pm, logic [1:0] pp,
    logic gd, logic uk, logic sk, logic nx,
    logic eg, logic [1:0] ep, logic ef, logic [7:0] ec);
    return {i, w, ne, xe, pr, sw, bh, bp, pm, pp, gd, uk, sk, nx, eg, ep, ef, ec};
  endfunction

  localparam logic [27:0] VEC [NV] = '{
    mk(0,0,0,0, 0,0, 0,0, 0,0, 0,0,0,0, 1,2,0,8'h00), // R1 data bypass
    mk(1,0,0,0, 0,0, 0,0, 0,0, 1,0,0,1, 1,2,0,8'h00), // R1 instr bypass
    mk(0,1,0,1, 0,0, 1,2, 0,0, 0,0,0,0, 1,2,0,8'h00), // R2 block rw write
    mk(0,0,0,1, 0,0, 1,1, 0,0, 0,0,0,0, 1,1,0,8'h00), // R2 block ro read
    mk(0,1,0,1, 0,0, 1,1, 0,0, 0,0,0,0, 0,0,1,8'h03), // R2 block ro write misses
    mk(0,0,0,1, 0,0, 1,0, 1,2, 0,0,0,0, 1,2,0,8'h00), // R2 block perm0 -> page
    mk(0,0,0,1, 0,0, 0,0, 1,3, 0,0,0,0, 1,1,0,8'h00), // R4 key0 pp3 read
    mk(0,1,0,1, 0,0, 0,0, 1,3, 0,0,0,0, 0,0,1,8'h03), // R4 key0 pp3 write
    mk(0,1,0,1, 0,0, 0,0, 1,0, 0,0,0,0, 1,2,0,8'h00), // R4 key0 pp0 write
    mk(0,0,0,1, 1,0, 0,0, 1,0, 0,1,0,0, 0,0,1,8'h03), // R3 user key pp0
    mk(0,0,0,1, 1,0, 0,0, 1,1, 0,1,0,0, 1,1,0,8'h00), // R4 key1 pp1 read
    mk(0,1,0,1, 1,0, 0,0, 1,1, 0,1,0,0, 0,0,1,8'h03), // R4 key1 pp1 write
    mk(0,1,0,1, 1,0, 0,0, 1,2, 0,1,0,0, 1,2,0,8'h00), // R4 key1 pp2 write
    mk(0,0,0,1, 1,0, 0,0, 1,3, 0,1,0,0, 1,1,0,8'h00), // R4 key1 pp3 read
    mk(0,0,0,1, 0,0, 0,0, 1,0, 0,0,1,0, 0,0,1,8'h03), // R3 supervisor key pp0
    mk(0,0,0,1, 1,0, 0,0, 1,0, 0,0,1,0, 1,2,0,8'h00), // R3 skey ignored in user
    mk(1,0,0,1, 0,0, 0,0, 1,2, 1,0,0,0, 0,0,1,8'h04), // R5 guarded fetch
    mk(1,0,0,1, 0,0, 0,0, 1,2, 0,0,0,1, 0,0,1,8'h04), // R5 noexec fetch
    mk(0,0,0,1, 0,0, 0,0, 1,2, 1,0,0,1, 1,2,0,8'h00), // R5 data ignores both
    mk(1,0,0,1, 0,1, 0,0, 0,0, 0,0,0,0, 0,0,1,8'h10), // R7 instr miss
    mk(0,0,0,1, 0,1, 0,0, 0,0, 0,0,0,0, 0,0,1,8'h11), // R7 load miss
    mk(0,1,0,1, 0,1, 0,0, 0,0, 0,0,0,0, 0,0,1,8'h12), // R7 store miss
    mk(0,0,1,1, 0,0, 0,0, 0,0, 0,0,0,0, 0,0,0,8'h00), // R8 suppressed
    mk(1,0,0,1, 0,0, 1,2, 0,0, 0,0,0,1, 1,2,0,8'h00)  // R2 block wins over noexec
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sw_reload = 0, cfg_instr_xlat_en = 0, cfg_data_xlat_en = 0, cfg_problem = 0;
  logic req_valid = 0, req_instr = 0, req_write = 0, req_no_exc = 0;
  logic [AW-1:0] req_vaddr = '0;
  logic blk_hit = 0;
  logic [1:0] blk_perm = '0;
  logic [AW-1:0] blk_paddr = '0;
  logic pg_match = 0, pg_guarded = 0;
  logic [1:0] pg_pp = '0;
  logic [AW-PB-1:0] pg_frame = '0;
  logic seg_ukey = 0, seg_skey = 0, seg_noexec = 0;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid, rsp_grant, fault_pulse, fault_tgpr;
  logic [1:0] rsp_perm;
  logic [AW-1:0] rsp_paddr, dfault_addr, imiss_addr, dmiss_addr;
  logic [7:0] fault_code;
  logic [31:0] dfault_status;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic seen_tgpr;

  always #5 clk = ~clk;

  xlat_fault_seq #(.AW(AW), .PAGE_BITS(PB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_sw_reload(cfg_sw_reload),
    .cfg_instr_xlat_en(cfg_instr_xlat_en), .cfg_data_xlat_en(cfg_data_xlat_en),
    .cfg_problem(cfg_problem), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_instr(req_instr), .req_write(req_write),
    .req_no_exc(req_no_exc), .blk_hit(blk_hit), .blk_perm(blk_perm),
    .blk_paddr(blk_paddr), .pg_match(pg_match), .pg_pp(pg_pp),
    .pg_guarded(pg_guarded), .pg_frame(pg_frame), .seg_ukey(seg_ukey),
    .seg_skey(seg_skey), .seg_noexec(seg_noexec), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_grant(rsp_grant), .rsp_perm(rsp_perm),
    .rsp_paddr(rsp_paddr), .fault_pulse(fault_pulse), .fault_code(fault_code),
    .fault_tgpr(fault_tgpr), .dfault_addr(dfault_addr),
    .dfault_status(dfault_status), .imiss_addr(imiss_addr), .dmiss_addr(dmiss_addr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [27:0] v, logic [AW-1:0] va, logic [AW-1:0] bpa, logic [AW-PB-1:0] fr);
    req_instr = v[27]; req_write = v[26]; req_no_exc = v[25];
    cfg_instr_xlat_en = v[24]; cfg_data_xlat_en = v[24];
    cfg_problem = v[23]; cfg_sw_reload = v[22];
    blk_hit = v[21]; blk_perm = v[20:19]; pg_match = v[18]; pg_pp = v[17:16];
    pg_guarded = v[15]; seg_ukey = v[14]; seg_skey = v[13]; seg_noexec = v[12];
    req_vaddr = va; blk_paddr = bpa; pg_frame = fr;
  endtask

  // Issues one request at a negedge; samples the response at the next negedge.
  task automatic issue(logic [27:0] v, logic [AW-1:0] va, logic [AW-1:0] bpa, logic [AW-PB-1:0] fr);
    drive(v, va, bpa, fr);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    seen_tgpr = fault_tgpr;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [AW-1:0] dar_keep, ds_keep;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 rsp_valid reset", {31'd0, rsp_valid}, 32'd0);
    check("R11 fault_pulse reset", {31'd0, fault_pulse}, 32'd0);
    check("R11 dfault_addr reset", dfault_addr, 32'd0);
    check("R11 dmiss reset", dmiss_addr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 ready idle", {31'd0, req_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      logic [AW-1:0] va, bpa, exp_pa;
      logic [AW-PB-1:0] fr;
      string tag;
      v   = VEC[i];
      va  = 32'h1000_0000 + i * 32'h0013_5791;
      bpa = 32'hC000_0A00 + i * 32'h10;
      fr  = 20'hAB000 + i[19:0];
      if (!v[11])      exp_pa = '0;
      else if (!v[24]) exp_pa = va;
      else if (v[21] && v[20:19] != 2'd0 && !(v[26] && v[20:19] == 2'd1)) exp_pa = bpa;
      else             exp_pa = {fr, va[PB-1:0]};
      tag = $sformatf("R1-table vec%0d", i);
      issue(v, va, bpa, fr);
      check({tag, " R2/R4 grant"}, {31'd0, rsp_grant}, {31'd0, v[11]});
      check({tag, " R4 perm"}, {30'd0, rsp_perm}, {30'd0, v[10:9]});
      check({tag, " R4 paddr"}, rsp_paddr, exp_pa);
      check({tag, " R10 pulse"}, {31'd0, fault_pulse}, {31'd0, v[8]});
      if (v[8]) check({tag, " R6/R7 code"}, {24'd0, fault_code}, {24'd0, v[7:0]});
      @(negedge clk);
      check({tag, " R10 pulse ends"}, {31'd0, fault_pulse}, 32'd0);
    end

    // R6 protection store fault status word
    issue(mk(0,1,0,1, 1,0, 0,0, 1,1, 0,1,0,0, 0,0,1,8'h03), 32'h2468_0ACE, '0, '0);
    check("R6 dar", dfault_addr, 32'h2468_0ACE);
    check("R6 status prot+store", dfault_status, 32'h0A00_0000);
    @(negedge clk);
    // R6 not-found load fault
    issue(mk(0,0,0,1, 0,0, 0,0, 0,0, 0,0,0,0, 0,0,1,8'h03), 32'h1357_9BDF, '0, '0);
    check("R6 dar nf", dfault_addr, 32'h1357_9BDF);
    check("R6 status notfound", dfault_status, 32'h4000_0000);
    @(negedge clk);
    // R6 instruction fault leaves data registers
    issue(mk(1,0,0,1, 0,0, 0,0, 0,0, 0,0,0,0, 0,0,1,8'h04), 32'h7777_0000, '0, '0);
    check("R6 instr code", {24'd0, fault_code}, 32'h04);
    check("R6 instr keeps dar", dfault_addr, 32'h1357_9BDF);
    @(negedge clk);
    // R7 store miss in software-reload mode
    issue(mk(0,1,0,1, 0,1, 0,0, 0,0, 0,0,0,0, 0,0,1,8'h12), 32'h5555_1234, '0, '0);
    check("R7 dmiss", dmiss_addr, 32'h5555_1234);
    check("R7 tgpr pulse", {31'd0, seen_tgpr}, 32'd1);
    check("R7 code store", {24'd0, fault_code}, 32'h12);
    check("R7 keeps dar", dfault_addr, 32'h1357_9BDF);
    check("R7 keeps status", dfault_status, 32'h4000_0000);
    @(negedge clk);
    check("R7 tgpr one cycle", {31'd0, fault_tgpr}, 32'd0);
    issue(mk(1,0,0,1, 0,1, 0,0, 0,0, 0,0,0,0, 0,0,1,8'h10), 32'h6666_4321, '0, '0);
    check("R7 imiss", imiss_addr, 32'h6666_4321);
    check("R11 dmiss held", dmiss_addr, 32'h5555_1234);
    @(negedge clk);
    // R8 suppressed faults touch nothing
    dar_keep = dfault_addr; ds_keep = dfault_status;
    issue(mk(0,1,1,1, 0,0, 0,0, 1,3, 0,0,0,0, 0,0,0,8'h00), 32'h9999_0000, '0, '0);
    check("R8 no pulse", {31'd0, fault_pulse}, 32'd0);
    check("R8 perm zero", {30'd0, rsp_perm}, 32'd0);
    check("R8 dar kept", dfault_addr, dar_keep);
    check("R8 status kept", dfault_status, ds_keep);
    issue(mk(0,0,1,1, 0,1, 0,0, 0,0, 0,0,0,0, 0,0,0,8'h00), 32'h9999_1000, '0, '0);
    check("R8 dmiss kept", dmiss_addr, 32'h5555_1234);
    check("R8 code kept", {24'd0, fault_code}, 32'h10);
    @(negedge clk);

    // R9/R10 back-pressure
    rsp_ready = 1'b0;
    issue(mk(0,0,0,1, 0,0, 0,0, 0,0, 0,0,0,0, 0,0,1,8'h03), 32'h4444_0000, '0, '0);
    check("R10 pulse first cycle", {31'd0, fault_pulse}, 32'd1);
    check("R9 ready low on stall", {31'd0, req_ready}, 32'd0);
    drive(mk(0,0,0,0, 0,0, 0,0, 0,0, 0,0,0,0, 0,0,0,8'h00), 32'h0BAD_0BAD, '0, '0);
    req_valid = 1'b1;
    @(negedge clk);
    check("R9 held valid", {31'd0, rsp_valid}, 32'd1);
    check("R9 held grant", {31'd0, rsp_grant}, 32'd0);
    check("R9 held paddr", rsp_paddr, 32'd0);
    check("R10 pulse single under stall", {31'd0, fault_pulse}, 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 stalled request taken", rsp_paddr, 32'h0BAD_0BAD);
    @(negedge clk);
    check("R9 drained", {31'd0, rsp_valid}, 32'd0);

    finish_run();
  end

endmodule